// File: doc/BRIEF.md
# Endpoint Address Translation Cache

This block sits inside a PCIe endpoint, between its DMA engines and the host's address translation service. A DMA engine presents an untranslated address on the lookup port. If a live entry covers that address, the block returns the translated address one cycle later. Otherwise it sends one translation request for the granule-aligned address to the host and stalls the lookup port until the matching completion comes back. A good completion returns the translated address and, while caching is allowed, fills an entry. A completion that reports a fault returns an error and leaves the cache unchanged.

Every mapping covers a power-of-two number of 4 KB pages, set by a 5-bit exponent. The host can purge any range of that shape at any time through the invalidation port. The block acknowledges each purge with a one-cycle done pulse, and a lookup never sees an entry that was hit by a purge in the same cycle. Caching is switched on and off by a control enable. Switching it off, or changing the exponent, drops every entry in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: After the synchronous reset the cache is empty, `lk_ready` is 1 and `res_valid`, `req_valid` and `inv_done` are 0.
- R2: A lookup accepted while `ctl_enable` is 1 that hits a live entry raises `res_valid` on the next cycle with `res_error` 0. The result address is the entry's translated base, plus the lookup's page-number bits below the granule, plus the lookup's low 12 address bits. No request is issued.
- R3: A lookup that misses raises `req_valid` for exactly one cycle on the next cycle and holds `lk_ready` at 0 until a completion arrives. The result appears on the cycle after the completion. Its address is the completion's base bits above the granule, plus the lookup's page bits below it, plus its low 12 bits.
- R4: With exponent n the granule is 2^n pages of 4 KB (n = 0 gives 4 KB). `req_addr` has every bit below 12+n at 0. Tag matching ignores the address bits below 12+n. An exponent at or above the page-number width makes one granule of the whole space.
- R5: While `ctl_enable` is 0, every lookup issues a request and no entry is filled. A fall of `ctl_enable` from 1 to 0 drops every entry at the next clock edge.
- R6: Any change of `ctl_unit_exp` drops every entry at the next clock edge.
- R7: A completion with `cpl_fault` 1 gives `res_error` 1 with `res_addr` 0 and creates no entry.
- R8: An invalidation covers the 2^`inv_exp` × 4 KB block that holds `inv_addr`. Every entry whose range overlaps that block is dropped, and `inv_done` pulses on the next cycle. A lookup in the same cycle as the invalidation sees the cache after the purge. A pending miss whose range overlaps an invalidation that arrives while it waits does not fill.
- R9: A fill takes the lowest-numbered free entry. When no entry is free, it takes the entry at a round-robin pointer that starts at 0 and advances by one on each such fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Caching allowed when 1 |
| ctl_unit_exp | input | 5 | Granule exponent n (2^n × 4 KB) |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle when 1 |
| lk_addr | input | ADDR_W | Untranslated address |
| res_valid | output | 1 | Result pulse |
| res_error | output | 1 | Result is a translation fault |
| res_addr | output | ADDR_W | Translated address |
| req_valid | output | 1 | Translation request pulse to the host |
| req_addr | output | ADDR_W | Granule-aligned untranslated address |
| cpl_valid | input | 1 | Translation completion from the host |
| cpl_fault | input | 1 | Completion reports a fault or rejection |
| cpl_addr | input | ADDR_W | Translated base from the host |
| inv_valid | input | 1 | Invalidation request from the host |
| inv_addr | input | ADDR_W | Address inside the block to purge |
| inv_exp | input | 5 | Size exponent of the purged block |
| inv_done | output | 1 | Invalidation completed pulse |

## Verification
The hardest case to reach from the ports is an invalidation that lands while a miss is still waiting for its completion and overlaps the pending range. If that completion filled an entry, later lookups would get a stale translation. The directed stimulus issues a miss, holds back the completion, sends an overlapping purge in the gap, then completes the miss and repeats the lookup to show that it still misses. The same-cycle case of a purge and a lookup to a cached range is driven in one cycle. A long random phase mixes lookups over more pages than there are entries, purges, faults, enable toggles and exponent changes against the bench's reference model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int EXP_W      = 5;

  typedef logic [EXP_W-1:0] gexp_t;
  typedef enum logic {ST_IDLE, ST_WAIT} xlat_state_e;

  // Bits at or above position e set, on a 64-bit page-number scale.
  function automatic logic [63:0] keep_above(input gexp_t e);
    return ~((64'd1 << e) - 64'd1);
  endfunction

  function automatic gexp_t exp_max(input gexp_t a, input gexp_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N_ENT = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ENT-1:0] free_vec,
  input  logic             fill_en,
  output logic [IDX_W-1:0] pick
);
  logic             found;
  logic [IDX_W-1:0] first_free;
  logic [IDX_W-1:0] rr;

  always_comb begin
    found      = 1'b0;
    first_free = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found      = 1'b1;
        first_free = IDX_W'(i);
      end
    end
  end

  assign pick = found ? first_free : rr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr <= '0;
    end else if (fill_en && !found) begin
      rr <= (rr == IDX_W'(N_ENT - 1)) ? '0 : rr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_tag_store.sv
module xlat_tag_store
  import xlat_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int PN_W  = 28,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill_all,
  input  logic             inv_valid,
  input  logic [PN_W-1:0]  inv_pn,
  input  gexp_t            inv_exp,
  input  logic [PN_W-1:0]  look_pn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [PN_W-1:0]  fill_tag,
  input  logic [PN_W-1:0]  fill_base,
  input  gexp_t            fill_exp,
  output logic [N_ENT-1:0] free_vec,
  output logic             hit,
  output logic [PN_W-1:0]  hit_pn
);
  logic [N_ENT-1:0] vld;
  logic [N_ENT-1:0] live;
  logic [N_ENT-1:0] hitv;
  logic [PN_W-1:0]  tag  [N_ENT];
  logic [PN_W-1:0]  base [N_ENT];
  gexp_t            ex   [N_ENT];
  logic [PN_W-1:0]  sel_pn [N_ENT];

  // Last invalidation, kept for the purge check below.
  logic             inv_seen_q;
  logic [PN_W-1:0]  inv_pn_q;
  gexp_t            inv_exp_q;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [63:0]     own_w, ovl_w, chk_w;
    logic [PN_W-1:0] own_m, ovl_m, chk_m;
    logic            inv_hit;

    assign own_w   = keep_above(ex[i]);
    assign own_m   = own_w[PN_W-1:0];
    assign ovl_w   = keep_above(exp_max(ex[i], inv_exp));
    assign ovl_m   = ovl_w[PN_W-1:0];
    assign inv_hit = ((tag[i] ^ inv_pn) & ovl_m) == '0;
    // Purge and flush take effect before the lookup compare.
    assign live[i] = vld[i] & ~kill_all & ~(inv_valid & inv_hit);
    assign hitv[i] = live[i] & (((look_pn ^ tag[i]) & own_m) == '0);
    assign sel_pn[i] = hitv[i] ? (base[i] | (look_pn & ~own_m)) : '0;

    assign chk_w = keep_above(exp_max(ex[i], inv_exp_q));
    assign chk_m = chk_w[PN_W-1:0];
    AST_INV_PURGED: assert property (@(posedge clk) disable iff (rst)
      inv_seen_q |-> !(vld[i] && (((tag[i] ^ inv_pn_q) & chk_m) == '0))); // R8
  end

  always_comb begin
    hit_pn = '0;
    for (int i = 0; i < N_ENT; i++) hit_pn = hit_pn | sel_pn[i];
  end

  assign hit      = |hitv;
  assign free_vec = ~live;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld        <= '0;
      inv_seen_q <= 1'b0;
      inv_pn_q   <= '0;
      inv_exp_q  <= '0;
    end else begin
      vld        <= live;
      if (fill_en) vld[fill_idx] <= 1'b1;
      inv_seen_q <= inv_valid;
      inv_pn_q   <= inv_pn;
      inv_exp_q  <= inv_exp;
    end
  end

  // Entry payload: written by index, no reset.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag[fill_idx]  <= fill_tag;
      base[fill_idx] <= fill_base;
      ex[fill_idx]   <= fill_exp;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitv)); // R4
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
    kill_all |=> (vld == '0)); // R5
  AST_FILL_SETS: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld[$past(fill_idx)]); // R9
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int N_ENT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_enable,
  input  logic [EXP_W-1:0]  ctl_unit_exp,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_error,
  output logic [ADDR_W-1:0] res_addr,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              cpl_valid,
  input  logic              cpl_fault,
  input  logic [ADDR_W-1:0] cpl_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [EXP_W-1:0]  inv_exp,
  output logic              inv_done
);
  localparam int PN_W  = ADDR_W - PAGE_SHIFT;
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  xlat_state_e           state;
  logic [PN_W-1:0]       look_pn, inv_pn, cpl_pn;
  logic [PAGE_SHIFT-1:0] page_off;
  logic [PN_W-1:0]       pend_pn;
  logic [PAGE_SHIFT-1:0] pend_off;
  gexp_t                 pend_exp;
  logic                  pend_ok;
  logic                  en_q;
  gexp_t                 exp_q;
  logic                  kill_all;
  logic [63:0]           cur_w, pend_w, povl_w;
  logic [PN_W-1:0]       cur_m, pend_m, povl_m;
  logic                  pend_hit_inv;
  logic                  take_cpl, fill_en;
  logic [N_ENT-1:0]      free_vec;
  logic [IDX_W-1:0]      fill_idx;
  logic                  hit;
  logic [PN_W-1:0]       hit_pn;
  logic                  unused_low;

  assign look_pn    = lk_addr[ADDR_W-1:PAGE_SHIFT];
  assign page_off   = lk_addr[PAGE_SHIFT-1:0];
  assign inv_pn     = inv_addr[ADDR_W-1:PAGE_SHIFT];
  assign cpl_pn     = cpl_addr[ADDR_W-1:PAGE_SHIFT];
  assign unused_low = ^{inv_addr[PAGE_SHIFT-1:0], cpl_addr[PAGE_SHIFT-1:0]};

  assign kill_all = (en_q & ~ctl_enable) | (ctl_unit_exp != exp_q);

  assign cur_w  = keep_above(ctl_unit_exp);
  assign cur_m  = cur_w[PN_W-1:0];
  assign pend_w = keep_above(pend_exp);
  assign pend_m = pend_w[PN_W-1:0];
  assign povl_w = keep_above(exp_max(pend_exp, inv_exp));
  assign povl_m = povl_w[PN_W-1:0];
  assign pend_hit_inv = inv_valid & (((pend_pn ^ inv_pn) & povl_m) == '0);

  assign lk_ready = (state == ST_IDLE);
  assign take_cpl = cpl_valid & (state == ST_WAIT);
  assign fill_en  = take_cpl & pend_ok & ctl_enable & ~cpl_fault &
                    (ctl_unit_exp == pend_exp) & ~pend_hit_inv;

  xlat_tag_store #(.N_ENT(N_ENT), .PN_W(PN_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .kill_all  (kill_all),
    .inv_valid (inv_valid),
    .inv_pn    (inv_pn),
    .inv_exp   (inv_exp),
    .look_pn   (look_pn),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_tag  (pend_pn & pend_m),
    .fill_base (cpl_pn & pend_m),
    .fill_exp  (pend_exp),
    .free_vec  (free_vec),
    .hit       (hit),
    .hit_pn    (hit_pn)
  );

  xlat_victim #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .free_vec (free_vec),
    .fill_en  (fill_en),
    .pick     (fill_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      res_valid <= 1'b0;
      res_error <= 1'b0;
      res_addr  <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      inv_done  <= 1'b0;
      pend_pn   <= '0;
      pend_off  <= '0;
      pend_exp  <= '0;
      pend_ok   <= 1'b0;
      en_q      <= 1'b0;
      exp_q     <= '0;
    end else begin
      res_valid <= 1'b0;
      req_valid <= 1'b0;
      inv_done  <= inv_valid;
      en_q      <= ctl_enable;
      exp_q     <= ctl_unit_exp;
      case (state)
        ST_IDLE: begin
          if (lk_valid) begin
            if (ctl_enable && hit) begin
              res_valid <= 1'b1;
              res_error <= 1'b0;
              res_addr  <= {hit_pn, page_off};
            end else begin
              req_valid <= 1'b1;
              req_addr  <= {look_pn & cur_m, {PAGE_SHIFT{1'b0}}};
              pend_pn   <= look_pn;
              pend_off  <= page_off;
              pend_exp  <= ctl_unit_exp;
              pend_ok   <= ctl_enable;
              state     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (pend_hit_inv || !ctl_enable) pend_ok <= 1'b0;
          if (cpl_valid) begin
            res_valid <= 1'b1;
            res_error <= cpl_fault;
            res_addr  <= cpl_fault ? '0 :
                         {(cpl_pn & pend_m) | (pend_pn & ~pend_m), pend_off};
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R3
  AST_REQ_NO_RES: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !res_valid && !lk_ready); // R3
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((req_addr[ADDR_W-1:PAGE_SHIFT] & ~pend_m) == '0) &&
                  (req_addr[PAGE_SHIFT-1:0] == '0)); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_error) |-> (res_addr == '0)); // R7
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int AW = 40;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_en = 1'b1;
  logic [4:0]    ctl_exp = '0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [AW-1:0] lk_addr = '0;
  logic          res_valid, res_error;
  logic [AW-1:0] res_addr;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          cpl_valid = 1'b0;
  logic          cpl_fault = 1'b0;
  logic [AW-1:0] cpl_addr = '0;
  logic          inv_valid = 1'b0;
  logic [AW-1:0] inv_addr = '0;
  logic [4:0]    inv_exp = '0;
  logic          inv_done;

  int n_chk = 0;
  int n_bad = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cache #(.ADDR_W(AW), .N_ENT(NE)) i_xlat_cache (
    .clk(clk), .rst(rst), .ctl_enable(ctl_en), .ctl_unit_exp(ctl_exp),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_error(res_error), .res_addr(res_addr),
    .req_valid(req_valid), .req_addr(req_addr),
    .cpl_valid(cpl_valid), .cpl_fault(cpl_fault), .cpl_addr(cpl_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_exp(inv_exp),
    .inv_done(inv_done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic bit same_blk(input longint a, input longint b, input int e);
    return (a >> e) == (b >> e);
  endfunction
  function automatic longint align(input longint a, input int e);
    return (a >> e) << e;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  bit            m_vld [NE];
  longint        m_tag [NE];
  longint        m_base[NE];
  int            m_exp [NE];
  int            m_rr, m_pexp, m_exp_q;
  bit            m_wait, m_pok, m_en_q;
  longint        m_pn, m_off;
  bit            e_ready, e_req_v, e_res_v, e_res_err, e_inv;
  logic [AW-1:0] e_req_a, e_res_a;

  always @(posedge clk) begin : model
    longint lpn, ipn, cpn;
    bit     kill, fill;
    bit     live[NE];
    int     hit, vic;
    if (rst) begin
      for (int i = 0; i < NE; i++) m_vld[i] = 1'b0;
      m_rr = 0; m_wait = 0; m_pok = 0; m_en_q = 0; m_exp_q = 0;
      e_ready = 1; e_req_v = 0; e_res_v = 0; e_inv = 0;
    end else begin
      lpn  = longint'(lk_addr >> 12);
      ipn  = longint'(inv_addr >> 12);
      cpn  = longint'(cpl_addr >> 12);
      kill = (m_en_q && !ctl_en) || (int'(ctl_exp) != m_exp_q);
      for (int i = 0; i < NE; i++)
        live[i] = m_vld[i] && !kill &&
                  !(inv_valid && same_blk(m_tag[i], ipn, mx(m_exp[i], int'(inv_exp))));
      e_req_v = 0; e_res_v = 0; e_inv = inv_valid; fill = 0;
      if (!m_wait) begin
        if (lk_valid) begin
          hit = -1;
          for (int i = 0; i < NE; i++)
            if (live[i] && same_blk(lpn, m_tag[i], m_exp[i])) hit = i;
          if (ctl_en && hit >= 0) begin
            e_res_v = 1; e_res_err = 0;
            e_res_a = AW'(((m_base[hit] + lpn - align(lpn, m_exp[hit])) << 12) |
                          longint'(lk_addr[11:0]));
          end else begin
            e_req_v = 1;
            e_req_a = AW'(align(lpn, int'(ctl_exp)) << 12);
            m_wait = 1; m_pn = lpn; m_off = longint'(lk_addr[11:0]);
            m_pexp = int'(ctl_exp); m_pok = ctl_en;
          end
        end
      end else begin
        if ((inv_valid && same_blk(m_pn, ipn, mx(m_pexp, int'(inv_exp)))) || !ctl_en)
          m_pok = 0;
        if (cpl_valid) begin
          e_res_v = 1; e_res_err = cpl_fault;
          e_res_a = cpl_fault ? '0 :
                    AW'(((align(cpn, m_pexp) + m_pn - align(m_pn, m_pexp)) << 12) | m_off);
          fill = m_pok && !cpl_fault && (int'(ctl_exp) == m_pexp);
          m_wait = 0;
        end
      end
      vic = -1;
      for (int i = NE - 1; i >= 0; i--) if (!live[i]) vic = i;
      for (int i = 0; i < NE; i++) m_vld[i] = live[i];
      if (fill) begin
        if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % NE; end
        m_vld[vic] = 1; m_tag[vic] = align(m_pn, m_pexp);
        m_base[vic] = align(cpn, m_pexp); m_exp[vic] = m_pexp;
      end
      m_en_q = ctl_en; m_exp_q = int'(ctl_exp);
      e_ready = !m_wait;
    end
  end

  always @(negedge clk) begin
    if (!rst && checking) begin
      check(lk_ready == e_ready, "R3 lk_ready", lk_ready, e_ready);
      check(req_valid == e_req_v, "R3 req_valid", req_valid, e_req_v);
      if (e_req_v) check(req_addr == e_req_a, "R4 req_addr", req_addr, e_req_a);
      check(res_valid == e_res_v, "R2 res_valid", res_valid, e_res_v);
      if (e_res_v) begin
        check(res_error == e_res_err, "R7 res_error", res_error, e_res_err);
        check(res_addr == e_res_a, "R2 res_addr", res_addr, e_res_a);
      end
      check(inv_done == e_inv, "R8 inv_done", inv_done, e_inv);
    end
  end

  // ---------------- stimulus ----------------
  bit            ms, er;
  logic [AW-1:0] ra, rq;

  task automatic lookup(input logic [AW-1:0] a, input logic [AW-1:0] cb, input bit flt);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
    ms = req_valid; rq = req_addr; ra = res_addr; er = res_error;
    if (ms) begin
      cpl_valid = 1; cpl_addr = cb; cpl_fault = flt;
      @(negedge clk); cpl_valid = 0; cpl_fault = 0;
      ra = res_addr; er = res_error;
    end
  endtask

  task automatic purge(input logic [AW-1:0] a, input logic [4:0] e);
    @(negedge clk); inv_valid = 1; inv_addr = a; inv_exp = e;
    @(negedge clk); inv_valid = 0;
    check(inv_done == 1, "R8 inv_done pulse", inv_done, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(lk_ready == 1, "R1 lk_ready after reset", lk_ready, 1);
    check(res_valid == 0 && req_valid == 0 && inv_done == 0, "R1 outputs idle",
          {res_valid, req_valid, inv_done}, 0);
    rst = 0; checking = 1;

    lookup(40'h0012345678, 40'h00ABCDE000, 0);
    check(ms == 1, "R3 first lookup misses", ms, 1);
    check(rq == 40'h0012345000, "R3 request address", rq, 40'h0012345000);
    check(ra == 40'h00ABCDE678, "R3 completion result", ra, 40'h00ABCDE678);
    lookup(40'h0012345FF0, 0, 0);
    check(ms == 0, "R2 same page hits", ms, 0);
    check(ra == 40'h00ABCDEFF0, "R2 hit result", ra, 40'h00ABCDEFF0);

    lookup(40'h0000777123, 0, 1);
    check(er == 1 && ra == 0, "R7 fault result", {er, ra}, {1'b1, 40'h0});
    lookup(40'h0000777123, 40'h0000999000, 0);
    check(ms == 1, "R7 fault left no entry", ms, 1);

    @(negedge clk); ctl_exp = 5'd2;
    lookup(40'h0012345678, 40'h0055550000, 0);
    check(ms == 1, "R6 exponent change flushed", ms, 1);
    check(rq == 40'h0012344000, "R4 request aligned to 16K", rq, 40'h0012344000);
    check(ra == 40'h0055551678, "R4 result in 16K granule", ra, 40'h0055551678);
    lookup(40'h0012347FF0, 0, 0);
    check(ms == 0 && ra == 40'h0055553FF0, "R4 hit anywhere in granule", ra, 40'h0055553FF0);
    lookup(40'h0012348000, 40'h0066660000, 0);
    check(ms == 1, "R4 next granule misses", ms, 1);

    purge(40'h0012346000, 5'd0);
    lookup(40'h0012345678, 40'h0077770000, 0);
    check(ms == 1, "R8 overlapping entry purged", ms, 1);
    lookup(40'h0012349000, 0, 0);
    check(ms == 0 && ra == 40'h0066661000, "R8 other entry kept", ra, 40'h0066661000);

    @(negedge clk); lk_valid = 1; lk_addr = 40'h001234A000;
    inv_valid = 1; inv_addr = 40'h001234B000; inv_exp = 5'd0;
    @(negedge clk); lk_valid = 0; inv_valid = 0;
    check(req_valid == 1, "R8 same-cycle purge applied first", req_valid, 1);
    cpl_valid = 1; cpl_addr = 40'h0088880000;
    @(negedge clk); cpl_valid = 0;
    check(res_addr == 40'h0088882000, "R3 result after stall", res_addr, 40'h0088882000);

    @(negedge clk); lk_valid = 1; lk_addr = 40'h0020000000;
    @(negedge clk); lk_valid = 0;
    inv_valid = 1; inv_addr = 40'h0020003000; inv_exp = 5'd0;
    @(negedge clk); inv_valid = 0;
    cpl_valid = 1; cpl_addr = 40'h0030000000;
    @(negedge clk); cpl_valid = 0;
    check(res_addr == 40'h0030000000, "R3 result despite purge", res_addr, 40'h0030000000);
    lookup(40'h0020000000, 40'h0030000000, 0);
    check(ms == 1, "R8 purge during wait blocked fill", ms, 1);

    @(negedge clk); ctl_en = 0;
    lookup(40'h0020000000, 40'h0030000000, 0);
    check(ms == 1, "R5 disable flushed entries", ms, 1);
    lookup(40'h0020000000, 40'h0030000000, 0);
    check(ms == 1, "R5 no fill while disabled", ms, 1);
    @(negedge clk); ctl_en = 1;
    lookup(40'h0020000000, 40'h0030000000, 0);
    check(ms == 1, "R5 nothing cached across disable", ms, 1);
    lookup(40'h0020000000, 0, 0);
    check(ms == 0, "R5 fill once enabled", ms, 0);

    @(negedge clk); ctl_exp = 5'd0;
    for (int k = 0; k < 9; k++) begin
      lookup(40'h0040000000 + AW'(k) * 40'h1000, 40'h0050000000 + AW'(k) * 40'h1000, 0);
      check(ms == 1, "R9 distinct page misses", ms, 1);
    end
    lookup(40'h0040001000, 0, 0);
    check(ms == 0, "R9 second entry survives", ms, 0);
    lookup(40'h0040000000, 40'h0050000000, 0);
    check(ms == 1, "R9 round-robin replaced entry 0", ms, 1);
    lookup(40'h0040002000, 0, 0);
    check(ms == 0, "R9 third entry survives", ms, 0);
    lookup(40'h0040001000, 40'h0050001000, 0);
    check(ms == 1, "R9 pointer advanced to entry 1", ms, 1);

    @(negedge clk); ctl_exp = 5'd31;
    lookup(40'h123456789A, 40'hFFFFF000, 0);
    check(ms == 1 && rq == 0, "R4 whole-space granule request", rq, 0);
    check(ra == 40'h123456789A, "R4 whole-space result", ra, 40'h123456789A);
    lookup(40'h0000000010, 0, 0);
    check(ms == 0 && ra == 40'h10, "R4 whole-space hit", ra, 40'h10);

    // random phase against the model
    @(negedge clk); ctl_exp = 5'd0;
    begin
      bit pend = 0;
      int wcnt = 0;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (req_valid) begin pend = 1; wcnt = $urandom_range(0, 3); end
        cpl_valid = 0; cpl_fault = 0; inv_valid = 0;
        if (pend) begin
          if (wcnt == 0) begin
            cpl_valid = 1; cpl_addr = AW'($urandom_range(0, 65535)) << 12;
            cpl_fault = ($urandom_range(0, 7) == 0); pend = 0;
          end else wcnt--;
        end
        lk_valid = ($urandom_range(0, 2) != 0);
        lk_addr  = (AW'($urandom_range(0, 31)) << 12) | AW'($urandom_range(0, 4095));
        inv_valid = ($urandom_range(0, 15) == 0);
        inv_addr  = AW'($urandom_range(0, 31)) << 12;
        inv_exp   = 5'($urandom_range(0, 3));
        if ($urandom_range(0, 199) == 0) ctl_en = ~ctl_en;
        if ($urandom_range(0, 299) == 0) ctl_exp = 5'($urandom_range(0, 3));
      end
      @(negedge clk); lk_valid = 0; inv_valid = 0; cpl_valid = 0;
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule